// File: doc/BRIEF.md
# Index Register Memory Transfer Unit

This unit holds a 16-bit index (pointer) register and carries out every operation that uses it to reach memory. It can load the index with a 12-bit constant, add an 8-bit register value to it, or point it at the 5-byte glyph of a hexadecimal digit in a font table. It can also split a register value into three decimal digits stored at the index, and copy a block of registers 0..X to or from memory starting at the index.

A sequencer that decodes instructions raises `start_i` for one cycle with an operation code, a register number X and an immediate. The unit then drives a byte-wide memory port and the read and write ports of the register file by itself, and pulses `done_o` once the operation is complete. Memory reads return their data one cycle after `mem_re_o`. Register file reads are combinational. A compatibility input makes block copies leave the index just past the copied block.

Top module: `idx_xfer_unit`

## Requirements
- R1: After reset `index_o` is 0 and `done_o` is low. While idle, `mem_we_o`, `mem_re_o` and `rf_we_o` stay low.
- R2: Op code 0 (load) sets the index to `imm_i` zero-extended to 16 bits.
- R3: Op code 1 (add) adds the register X value, zero-extended, to the index modulo 2^16.
- R4: Op code 2 (glyph) sets the index to FONT_BASE + 5 * (register X value mod 16). FONT_BASE defaults to 0x050.
- R5: Op code 3 (digits) writes the hundreds digit of register X to address index, the tens digit to index+1 and the ones digit to index+2. Each digit is a byte from 0 to 9. `done_o` arrives at most 16 cycles after the start cycle and the index is unchanged.
- R6: Op code 4 (store) writes register 0..X to address index..index+X. It makes one write per cycle in ascending order, and addresses wrap modulo 4096.
- R7: Op code 5 (load block) reads address index..index+X into registers 0..X and leaves the other registers untouched. Each register write takes the data of the read issued one cycle before.
- R8: After a store or load block the index grows by X+1 when `compat_i` was set at start. Otherwise it is unchanged. The index changes only in the cycle `done_o` is high.
- R9: `done_o` is a one-cycle pulse. A `start_i` raised while an operation is running is ignored. Op codes 6 and 7 only pulse `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (taken when idle) |
| op_i | input | 3 | Operation code |
| sel_i | input | 4 | Register number X |
| imm_i | input | 12 | Immediate for the load operation |
| compat_i | input | 1 | Advance index after block copies |
| rf_raddr_o | output | 4 | Register file read address |
| rf_rdata_i | input | 8 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 4 | Register file write address |
| rf_wdata_o | output | 8 | Register file write data |
| mem_addr_o | output | 12 | Memory byte address |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable (data next cycle) |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| index_o | output | 16 | Current index register |
| done_o | output | 1 | Operation complete pulse |

## Verification
The bench builds the unit with its default parameters: 16 registers, a 12-bit address space, a font base of 0x050 and a glyph stride of 5. The full register count lets a block copy of all 16 registers start at 0xFF8 and cross the 4096-byte wrap. The index is 16 bits wide, so the same copy with the compatibility input set carries the index past 0xFFF to 0x1008.

// File: rtl/idx_xfer_pkg.sv
package idx_xfer_pkg;
    localparam logic [2:0] OP_LDI    = 3'd0;
    localparam logic [2:0] OP_ADD    = 3'd1;
    localparam logic [2:0] OP_GLYPH  = 3'd2;
    localparam logic [2:0] OP_DIGITS = 3'd3;
    localparam logic [2:0] OP_STORE  = 3'd4;
    localparam logic [2:0] OP_LOAD   = 3'd5;

    typedef enum logic [2:0] {
        S_IDLE, S_EXEC, S_TENS, S_DIG, S_XFER, S_DRAIN
    } st_e;
endpackage

// File: rtl/idx_calc.sv
module idx_calc
    import idx_xfer_pkg::*;
#(
    parameter int IDX_W        = 16,
    parameter int ADDR_W       = 12,
    parameter int XW           = 4,
    parameter int FONT_BASE    = 'h050,
    parameter int GLYPH_STRIDE = 5
) (
    input  logic [2:0]        op,
    input  logic [IDX_W-1:0]  index,
    input  logic [ADDR_W-1:0] imm,
    input  logic [7:0]        rdata,
    input  logic [XW-1:0]     x,
    input  logic              compat,
    output logic [IDX_W-1:0]  index_next
);
    always_comb begin
        case (op)
            OP_LDI:   index_next = IDX_W'(imm);
            OP_ADD:   index_next = index + IDX_W'(rdata);
            OP_GLYPH: index_next = IDX_W'(FONT_BASE)
                                 + IDX_W'(GLYPH_STRIDE) * IDX_W'(rdata[3:0]);
            OP_STORE, OP_LOAD:
                index_next = compat ? index + IDX_W'(x) + IDX_W'(1) : index;
            default:  index_next = index;
        endcase
    end
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen #(
    parameter int IDX_W  = 16,
    parameter int ADDR_W = 12,
    parameter int XW     = 4
) (
    input  logic [IDX_W-1:0]  index,
    input  logic [XW-1:0]     offset,
    output logic [ADDR_W-1:0] addr
);
    // Address space wraps: only the low ADDR_W bits of the sum survive.
    assign addr = index[ADDR_W-1:0] + ADDR_W'(offset);
endmodule

// File: rtl/idx_hund_split.sv
module idx_hund_split (
    input  logic [7:0] value,
    output logic [1:0] hund,
    output logic [7:0] rem
);
    always_comb begin
        if (value >= 8'd200) begin
            hund = 2'd2;
            rem  = value - 8'd200;
        end else if (value >= 8'd100) begin
            hund = 2'd1;
            rem  = value - 8'd100;
        end else begin
            hund = 2'd0;
            rem  = value;
        end
    end
endmodule

// File: rtl/idx_xfer_unit.sv
module idx_xfer_unit
    import idx_xfer_pkg::*;
#(
    parameter int IDX_W        = 16,
    parameter int ADDR_W       = 12,
    parameter int NREG         = 16,
    parameter int FONT_BASE    = 'h050,
    parameter int GLYPH_STRIDE = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [2:0]              op_i,
    input  logic [$clog2(NREG)-1:0] sel_i,
    input  logic [ADDR_W-1:0]       imm_i,
    input  logic                    compat_i,
    output logic [$clog2(NREG)-1:0] rf_raddr_o,
    input  logic [7:0]              rf_rdata_i,
    output logic                    rf_we_o,
    output logic [$clog2(NREG)-1:0] rf_waddr_o,
    output logic [7:0]              rf_wdata_o,
    output logic [ADDR_W-1:0]       mem_addr_o,
    output logic                    mem_we_o,
    output logic                    mem_re_o,
    output logic [7:0]              mem_wdata_o,
    input  logic [7:0]              mem_rdata_i,
    output logic [IDX_W-1:0]        index_o,
    output logic                    done_o
);
    localparam int XW = $clog2(NREG);

    typedef struct packed {
        st_e               st;
        logic [2:0]        op;
        logic [XW-1:0]     x;
        logic [ADDR_W-1:0] imm;
        logic              compat;
        logic [IDX_W-1:0]  index;
        logic [XW-1:0]     cnt;
        logic [7:0]        work;
        logic [3:0]        tens;
        logic [3:0]        hund;
        logic              done;
        logic              pend;
        logic [XW-1:0]     pend_reg;
    } state_t;

    state_t cur_q, nxt_d;
    logic [IDX_W-1:0] calc_index;
    logic [XW-1:0]    offset;
    logic [1:0]       h_split;
    logic [7:0]       r_split;

    idx_calc #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .XW(XW),
        .FONT_BASE(FONT_BASE), .GLYPH_STRIDE(GLYPH_STRIDE)
    ) i_calc (
        .op(cur_q.op), .index(cur_q.index), .imm(cur_q.imm),
        .rdata(rf_rdata_i), .x(cur_q.x), .compat(cur_q.compat),
        .index_next(calc_index)
    );

    idx_addr_gen #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .XW(XW)) i_addr (
        .index(cur_q.index), .offset(offset), .addr(mem_addr_o)
    );

    idx_hund_split i_split (.value(rf_rdata_i), .hund(h_split), .rem(r_split));

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.done  = 1'b0;
        nxt_d.pend  = 1'b0;
        rf_raddr_o  = cur_q.x;
        offset      = cur_q.cnt;
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_wdata_o = '0;
        case (cur_q.st)
            S_IDLE: begin
                if (start_i) begin
                    nxt_d.op     = op_i;
                    nxt_d.x      = sel_i;
                    nxt_d.imm    = imm_i;
                    nxt_d.compat = compat_i;
                    nxt_d.st     = S_EXEC;
                end
            end
            S_EXEC: begin
                if (cur_q.op == OP_DIGITS) begin
                    nxt_d.hund = 4'(h_split);
                    nxt_d.work = r_split;
                    nxt_d.tens = '0;
                    nxt_d.st   = S_TENS;
                end else if (cur_q.op == OP_STORE || cur_q.op == OP_LOAD) begin
                    nxt_d.cnt = '0;
                    nxt_d.st  = S_XFER;
                end else begin
                    nxt_d.index = calc_index;
                    nxt_d.done  = 1'b1;
                    nxt_d.st    = S_IDLE;
                end
            end
            S_TENS: begin
                if (cur_q.work >= 8'd10) begin
                    nxt_d.work = cur_q.work - 8'd10;
                    nxt_d.tens = cur_q.tens + 4'd1;
                end else begin
                    nxt_d.cnt = '0;
                    nxt_d.st  = S_DIG;
                end
            end
            S_DIG: begin
                mem_we_o = 1'b1;
                if (cur_q.cnt == XW'(0))      mem_wdata_o = 8'(cur_q.hund);
                else if (cur_q.cnt == XW'(1)) mem_wdata_o = 8'(cur_q.tens);
                else                          mem_wdata_o = cur_q.work;
                if (cur_q.cnt == XW'(2)) begin
                    nxt_d.done = 1'b1;
                    nxt_d.st   = S_IDLE;
                end else begin
                    nxt_d.cnt = cur_q.cnt + XW'(1);
                end
            end
            S_XFER: begin
                rf_raddr_o = cur_q.cnt;
                if (cur_q.op == OP_STORE) begin
                    mem_we_o    = 1'b1;
                    mem_wdata_o = rf_rdata_i;
                end else begin
                    mem_re_o       = 1'b1;
                    nxt_d.pend     = 1'b1;
                    nxt_d.pend_reg = cur_q.cnt;
                end
                if (cur_q.cnt == cur_q.x) begin
                    if (cur_q.op == OP_STORE) begin
                        nxt_d.index = calc_index;
                        nxt_d.done  = 1'b1;
                        nxt_d.st    = S_IDLE;
                    end else begin
                        nxt_d.st = S_DRAIN;
                    end
                end else begin
                    nxt_d.cnt = cur_q.cnt + XW'(1);
                end
            end
            S_DRAIN: begin
                nxt_d.index = calc_index;
                nxt_d.done  = 1'b1;
                nxt_d.st    = S_IDLE;
            end
            default: nxt_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rf_we_o    = cur_q.pend;
    assign rf_waddr_o = cur_q.pend_reg;
    assign rf_wdata_o = mem_rdata_i;
    assign index_o    = cur_q.index;
    assign done_o     = cur_q.done;

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_IDLE) |-> (!mem_we_o && !mem_re_o));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r5_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_DIG) |-> (mem_wdata_o <= 8'd9));
    a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == S_XFER && $past(cur_q.st) == S_XFER)
        |-> ((mem_addr_o - $past(mem_addr_o)) == ADDR_W'(1)));
    a_r6_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we_o, mem_re_o}));
    a_r7_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> $past(mem_re_o));
    a_r8_index_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(index_o));
endmodule

// File: tb/test_idx_xfer_unit.sv
module test_idx_xfer_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [3:0]  sel_i = '0;
    logic [11:0] imm_i = '0;
    logic        compat_i = 1'b0;
    logic [3:0]  rf_raddr_o, rf_waddr_o;
    logic [7:0]  rf_rdata_i, rf_wdata_o, mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        rf_we_o, mem_we_o, mem_re_o, done_o;
    logic [11:0] mem_addr_o;
    logic [15:0] index_o;

    logic [7:0] rf [16];
    logic [7:0] mem [4096];
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_rdata_i = rf[rf_raddr_o];
    always @(posedge clk) begin
        if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
        if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
        if (mem_re_o) mem_rdata_i <= mem[mem_addr_o];
    end

    idx_xfer_unit i_idx_xfer_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .sel_i(sel_i), .imm_i(imm_i), .compat_i(compat_i),
        .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
        .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .index_o(index_o), .done_o(done_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [3:0] x,
                          input logic [11:0] imm, input logic cmp, output int cyc);
        @(negedge clk);
        start_i = 1'b1; op_i = op; sel_i = x; imm_i = imm; compat_i = cmp;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        check("R9 done arrives", 32'(done_o), 32'd1);
    endtask

    task automatic t_reset();
        check("R1 reset index", 32'(index_o), 32'h0);
        check("R1 reset done", 32'(done_o), 32'h0);
        check("R1 idle no writes", 32'({mem_we_o, mem_re_o, rf_we_o}), 32'h0);
    endtask

    task automatic t_load_add();
        int c;
        run_op(3'd0, 4'd0, 12'h3A7, 1'b0, c);
        check("R2 load immediate", 32'(index_o), 32'h03A7);
        @(negedge clk);
        check("R9 done one cycle", 32'(done_o), 32'h0);
        rf[5] = 8'hFF;
        run_op(3'd1, 4'd5, 12'h000, 1'b0, c);
        check("R3 add zero-extended", 32'(index_o), 32'h04A6);
    endtask

    task automatic t_glyph();
        int c;
        rf[2] = 8'h1B;
        run_op(3'd2, 4'd2, 12'h000, 1'b0, c);
        check("R4 glyph mod 16", 32'(index_o), 32'h0087);
        rf[3] = 8'h07;
        run_op(3'd2, 4'd3, 12'h000, 1'b0, c);
        check("R4 glyph 7", 32'(index_o), 32'h0073);
    endtask

    task automatic t_digits(input logic [7:0] v);
        int c;
        int base;
        run_op(3'd0, 4'd0, 12'h300, 1'b0, c);
        rf[9] = v;
        run_op(3'd3, 4'd9, 12'h000, 1'b0, c);
        base = 'h300;
        check("R5 hundreds", 32'(mem[base]), 32'(v / 100));
        check("R5 tens", 32'(mem[base + 1]), 32'((v / 10) % 10));
        check("R5 ones", 32'(mem[base + 2]), 32'(v % 10));
        check("R5 within 16 cycles", 32'(c <= 16), 32'd1);
        check("R5 index unchanged", 32'(index_o), 32'h0300);
    endtask

    task automatic t_store_plain();
        int c;
        for (int i = 0; i < 16; i++) rf[i] = 8'(8'hA0 + i);
        mem[12'h104] = 8'h5C;
        run_op(3'd0, 4'd0, 12'h100, 1'b0, c);
        run_op(3'd4, 4'd3, 12'h000, 1'b0, c);
        for (int i = 0; i < 4; i++) check("R6 store byte", 32'(mem[12'h100 + i]), 32'(8'hA0 + i));
        check("R6 store stops at X", 32'(mem[12'h104]), 32'h5C);
        check("R8 no compat index kept", 32'(index_o), 32'h0100);
    endtask

    task automatic t_store_wrap();
        int c;
        run_op(3'd0, 4'd0, 12'hFF8, 1'b0, c);
        run_op(3'd4, 4'd15, 12'h000, 1'b1, c);
        for (int i = 0; i < 16; i++)
            check("R6 store wraps", 32'(mem[(12'hFF8 + i) % 4096]), 32'(8'hA0 + i));
        check("R8 compat advance", 32'(index_o), 32'h1008);
    endtask

    task automatic t_load_block();
        int c;
        for (int i = 0; i < 8; i++) mem[12'h200 + i] = 8'(8'h30 + 3 * i);
        for (int i = 0; i < 16; i++) rf[i] = 8'hEE;
        run_op(3'd0, 4'd0, 12'h200, 1'b0, c);
        run_op(3'd5, 4'd4, 12'h000, 1'b1, c);
        for (int i = 0; i < 5; i++) check("R7 load byte", 32'(rf[i]), 32'(8'h30 + 3 * i));
        check("R7 reg above X untouched", 32'(rf[5]), 32'hEE);
        check("R8 compat load advance", 32'(index_o), 32'h0205);
        run_op(3'd5, 4'd0, 12'h000, 1'b0, c);
        check("R7 single load", 32'(rf[0]), 32'(mem[12'h205]));
        check("R8 load no compat", 32'(index_o), 32'h0205);
    endtask

    task automatic t_misc();
        int c;
        run_op(3'd7, 4'd0, 12'hFFF, 1'b1, c);
        check("R9 unused op keeps index", 32'(index_o), 32'h0205);
        rf[1] = 8'd99;
        @(negedge clk);
        start_i = 1'b1; op_i = 3'd3; sel_i = 4'd1; compat_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1; op_i = 3'd0; imm_i = 12'hABC;
        @(negedge clk);
        start_i = 1'b0;
        c = 0;
        while (!done_o && c < 40) begin @(negedge clk); c++; end
        check("R9 busy start ignored", 32'(index_o), 32'h0205);
        check("R5 digits during busy", 32'({mem[12'h205], mem[12'h206], mem[12'h207]}), 32'h000909);
        repeat (3) @(negedge clk);
        check("R9 stays idle", 32'({done_o, index_o}), 32'h0205);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        for (int i = 0; i < 16; i++) rf[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_add();
        t_glyph();
        t_digits(8'd0);
        t_digits(8'd99);
        t_digits(8'd100);
        t_digits(8'd255);
        t_digits(8'd47);
        t_store_plain();
        t_store_wrap();
        t_load_block();
        t_misc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule